// File: doc/BRIEF.md
# Multi-Input Event Builder Framer

This block collects one readout event from a set of front-end inputs and sends it out as a framed sequence of 64-bit words. A start handshake supplies the header fields for the event: type, trigger number, crossing number, source number and format version. The block first emits a header word. It then visits each enabled input in ascending index order and drains that input's block of 16-bit words. The words are packed four to one output word, and the packing runs on without a break from one input to the next. Each input block already holds its own three header words, its data words and its trailer word. After the payload the block may add an all-zero pad word. It ends the event with a trailer word that holds the total length, a CRC and a status byte.

All data interfaces use valid/ready. A word or beat transfers only in a cycle where both valid and ready are high. While `out_ready` is low, `out_data`, `out_last` and `out_valid` do not change and every `in_ready` stays low, so no input word is consumed. An input whose block is missing for this event presents a single beat with `in_absent` high. The block consumes that beat, adds no payload for it and flags it in the status byte. A `resync` pulse discards the event in progress and returns the block to idle in the next cycle.

Top module: `evb_framer`

## Requirements
- R1: At reset, and after each event ends, `start_ready` is high. A start transfer causes a header word to be emitted. Its layout is [63:60]=4'h5, [59:56]=type, [55:32]=trigger number, [31:20]=crossing number, [19:8]=source number, [7:4]=version and [3:0]=0.
- R2: The payload is the 16-bit words of the enabled inputs, taken in ascending input index order and packed four per output word. The earliest word goes in bits [63:48], the next in [47:32], and so on. Packing runs across input block boundaries, and only the final payload word is zero-filled in its unused low lanes.
- R3: A disabled input never sees `in_ready` high, and a beat it holds is left unconsumed.
- R4: An enabled input that presents a beat with `in_absent` high gives up that single beat and adds no payload words.
- R5: An all-zero pad word follows the payload exactly when the payload word count is odd, so the event length is always even.
- R6: The last word of an event has `out_last` high and the layout [63:60]=4'hA, [59:56]=0, [55:32]=length, [31:16]=CRC, [15:8]=status and [7:0]=0. The length counts every word from the header through the trailer.
- R7: The CRC uses polynomial 0x1021 and starts at 0xFFFF. It shifts in each word MSB first: every word before the trailer, then the trailer itself with its CRC field set to zero.
- R8: Status bits [6:0] are the OR of the `in_err` values of all enabled inputs, each taken on that input's first beat. Status bit 7 is set when an enabled input is absent or its `in_evn` differs from the trigger number.
- R9: While `out_valid` is high and `out_ready` is low, the output word, `out_last` and `out_valid` hold into the next cycle, and all `in_ready` are low.
- R10: One cycle after `resync` is high, `out_valid` is low and `start_ready` is high. Partial packing state is dropped, so the next event is framed cleanly.
- R11: After reset, `out_valid` and all `in_ready` are low.
- R12: At most one `in_ready` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Synchronous return to idle, discarding the current event |
| en_mask | input | N_IN | Inputs taking part in events |
| start_valid | input | 1 | Start request with header fields |
| start_ready | output | 1 | High when idle and able to accept a start |
| start_type | input | 4 | Event type |
| start_l1 | input | 24 | Trigger number |
| start_bx | input | 12 | Bunch-crossing number |
| start_src | input | 12 | Source number |
| start_fov | input | 4 | Format version |
| in_valid | input | N_IN | Per-input beat valid |
| in_ready | output | N_IN | Per-input beat ready |
| in_data | input | 16*N_IN | Per-input 16-bit word |
| in_last | input | N_IN | Beat is the last of the input's block |
| in_absent | input | N_IN | Beat marks the block as missing |
| in_err | input | 7*N_IN | Per-input error flags |
| in_evn | input | 24*N_IN | Per-input event number |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output sink ready |
| out_data | output | 64 | Output word |
| out_last | output | 1 | Output word is the event trailer |

## Verification
Every output word comes from a register. A transfer seen in one cycle therefore decides the word that appears on the port one cycle later. An input beat accepted at an edge shows up at the output no earlier than the edge that completes its packed word. The bench's reference model does not track those latencies. It builds the exact expected word sequence for each event, including pad, length and CRC. Each clock it compares the head of that queue against the port half a cycle after the edge, and it pops the head only when the sampled cycle carried a transfer. Hold behaviour under back-pressure is checked one cycle after each stalled cycle. The resync result is checked in the cycle after the pulse.

// File: rtl/evb_pkg.sv
`timescale 1ns/1ps
package evb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_PAY, ST_FLUSH, ST_PAD, ST_TRL
  } evb_state_e;

  localparam int WORD_W = 16;
  localparam int LANES  = 4;
  localparam int ERR_W  = 7;
  localparam int EVN_W  = 24;
  localparam int BX_W   = 12;
  localparam int SRC_W  = 12;
  localparam int TYP_W  = 4;
  localparam int FOV_W  = 4;
  localparam int LEN_W  = 24;
  localparam int ACC_W  = WORD_W * (LANES - 1);

  localparam logic [3:0]  BEGIN_MARK = 4'h5;
  localparam logic [3:0]  END_MARK   = 4'hA;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;

  function automatic logic [15:0] crc16_w64(input logic [15:0] c, input logic [63:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int b = 63; b >= 0; b--) begin
      fb = r[15] ^ d[b];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/evb_crc16.sv
`timescale 1ns/1ps
module evb_crc16
  import evb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [63:0] din,
  output logic [15:0] crc_q,
  output logic [15:0] crc_nxt
);
  assign crc_nxt = crc16_w64(crc_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (clr)  crc_q <= CRC_SEED;
    else if (upd)  crc_q <= crc_nxt;
  end
endmodule

// File: rtl/evb_in_sel.sv
`timescale 1ns/1ps
module evb_in_sel
  import evb_pkg::*;
#(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]        en_mask,
  input  logic [IW-1:0]       cur,
  input  logic [N-1:0]        in_valid,
  input  logic [N*WORD_W-1:0] in_data,
  input  logic [N-1:0]        in_last,
  input  logic [N-1:0]        in_absent,
  input  logic [N*ERR_W-1:0]  in_err,
  input  logic [N*EVN_W-1:0]  in_evn,
  output logic                sel_valid,
  output logic [WORD_W-1:0]   sel_data,
  output logic                sel_last,
  output logic                sel_absent,
  output logic [ERR_W-1:0]    sel_err,
  output logic [EVN_W-1:0]    sel_evn,
  output logic                first_found,
  output logic [IW-1:0]       first_idx,
  output logic                next_found,
  output logic [IW-1:0]       next_idx
);
  always_comb begin
    sel_valid  = 1'b0;
    sel_data   = '0;
    sel_last   = 1'b0;
    sel_absent = 1'b0;
    sel_err    = '0;
    sel_evn    = '0;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) == cur) begin
        sel_valid  = in_valid[i];
        sel_data   = in_data[i*WORD_W +: WORD_W];
        sel_last   = in_last[i];
        sel_absent = in_absent[i];
        sel_err    = in_err[i*ERR_W +: ERR_W];
        sel_evn    = in_evn[i*EVN_W +: EVN_W];
      end
    end
  end

  // lowest enabled index overall, and lowest enabled index above cur
  always_comb begin
    first_found = 1'b0;
    first_idx   = '0;
    next_found  = 1'b0;
    next_idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en_mask[i]) begin
        first_found = 1'b1;
        first_idx   = IW'(i);
        if (i > int'(cur)) begin
          next_found = 1'b1;
          next_idx   = IW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/evb_framer.sv
`timescale 1ns/1ps
module evb_framer
  import evb_pkg::*;
#(
  parameter int N_IN = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   resync,
  input  logic [N_IN-1:0]        en_mask,
  input  logic                   start_valid,
  output logic                   start_ready,
  input  logic [TYP_W-1:0]       start_type,
  input  logic [EVN_W-1:0]       start_l1,
  input  logic [BX_W-1:0]        start_bx,
  input  logic [SRC_W-1:0]       start_src,
  input  logic [FOV_W-1:0]       start_fov,
  input  logic [N_IN-1:0]        in_valid,
  output logic [N_IN-1:0]        in_ready,
  input  logic [N_IN*WORD_W-1:0] in_data,
  input  logic [N_IN-1:0]        in_last,
  input  logic [N_IN-1:0]        in_absent,
  input  logic [N_IN*ERR_W-1:0]  in_err,
  input  logic [N_IN*EVN_W-1:0]  in_evn,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [63:0]            out_data,
  output logic                   out_last
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

  evb_state_e        st;
  logic [IW-1:0]     cur;
  logic              first_beat;
  logic [TYP_W-1:0]  h_type;
  logic [EVN_W-1:0]  h_l1;
  logic [BX_W-1:0]   h_bx;
  logic [SRC_W-1:0]  h_src;
  logic [FOV_W-1:0]  h_fov;
  logic [ACC_W-1:0]  acc;
  logic [1:0]        lane;
  logic [LEN_W-1:0]  pay_cnt;
  logic [ERR_W-1:0]  err_or;
  logic              miss;

  logic              ld_ok, start_fire, take;
  logic              sel_valid, sel_last, sel_absent;
  logic [WORD_W-1:0] sel_data;
  logic [ERR_W-1:0]  sel_err;
  logic [EVN_W-1:0]  sel_evn;
  logic              first_found, next_found;
  logic [IW-1:0]     first_idx, next_idx;
  logic              emit;
  logic [63:0]       emit_word, hdr_word, trl_zero;
  logic [LEN_W-1:0]  ev_len;
  logic [15:0]       crc_q, crc_nxt;

  assign ld_ok       = !out_valid || out_ready;
  assign start_ready = (st == ST_IDLE);
  assign start_fire  = start_valid && start_ready;
  assign take        = (st == ST_PAY) && sel_valid && ld_ok;

  assign hdr_word = {BEGIN_MARK, h_type, h_l1, h_bx, h_src, h_fov, 4'h0};
  assign ev_len   = pay_cnt + LEN_W'(2) + LEN_W'(pay_cnt[0]);
  assign trl_zero = {END_MARK, 4'h0, ev_len, 16'h0, miss, err_or, 8'h0};

  evb_in_sel #(.N(N_IN), .IW(IW)) u_sel (
    .en_mask(en_mask), .cur(cur),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_absent(in_absent), .in_err(in_err), .in_evn(in_evn),
    .sel_valid(sel_valid), .sel_data(sel_data), .sel_last(sel_last),
    .sel_absent(sel_absent), .sel_err(sel_err), .sel_evn(sel_evn),
    .first_found(first_found), .first_idx(first_idx),
    .next_found(next_found), .next_idx(next_idx)
  );

  evb_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start_fire || resync), .upd(emit),
    .din(emit_word), .crc_q(crc_q), .crc_nxt(crc_nxt)
  );

  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_rdy
      assign in_ready[g] = (st == ST_PAY) && (cur == IW'(g)) && ld_ok;
    end
  endgenerate

  always_comb begin
    emit      = 1'b0;
    emit_word = '0;
    case (st)
      ST_HDR:   begin emit = ld_ok;                                emit_word = hdr_word; end
      ST_PAY:   begin emit = take && !sel_absent && (lane == 2'd3); emit_word = {acc, sel_data}; end
      ST_FLUSH: begin emit = ld_ok && (lane != 2'd0);              emit_word = {acc, 16'h0}; end
      ST_PAD:   begin emit = ld_ok && pay_cnt[0];                  emit_word = '0; end
      ST_TRL:   begin emit = ld_ok;                                emit_word = trl_zero; end
      default:  ;
    endcase
  end

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (resync) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_last  <= (st == ST_TRL);
      out_data  <= (st == ST_TRL) ? {trl_zero[63:32], crc_nxt, trl_zero[15:0]} : emit_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // framing sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cur <= '0; first_beat <= 1'b1;
      h_type <= '0; h_l1 <= '0; h_bx <= '0; h_src <= '0; h_fov <= '0;
      acc <= '0; lane <= '0; pay_cnt <= '0; err_or <= '0; miss <= 1'b0;
    end else if (resync) begin
      st <= ST_IDLE; cur <= '0; first_beat <= 1'b1;
      acc <= '0; lane <= '0; pay_cnt <= '0; err_or <= '0; miss <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_fire) begin
          h_type <= start_type; h_l1 <= start_l1; h_bx <= start_bx;
          h_src <= start_src; h_fov <= start_fov;
          acc <= '0; lane <= '0; pay_cnt <= '0; err_or <= '0; miss <= 1'b0;
          first_beat <= 1'b1;
          st <= ST_HDR;
        end
        ST_HDR: if (ld_ok) begin
          cur <= first_idx;
          st  <= first_found ? ST_PAY : ST_FLUSH;
        end
        ST_PAY: if (take) begin
          if (first_beat) begin
            err_or <= err_or | sel_err;
            if (sel_absent || (sel_evn != h_l1)) miss <= 1'b1;
          end
          if (!sel_absent) begin
            if (lane == 2'd3) begin
              acc     <= '0;
              lane    <= '0;
              pay_cnt <= pay_cnt + 1'b1;
            end else begin
              acc[(2 - int'(lane))*WORD_W +: WORD_W] <= sel_data;
              lane <= lane + 1'b1;
            end
          end
          if (sel_last || sel_absent) begin
            first_beat <= 1'b1;
            if (next_found) cur <= next_idx;
            else            st  <= ST_FLUSH;
          end else begin
            first_beat <= 1'b0;
          end
        end
        ST_FLUSH: begin
          if (lane == 2'd0) st <= ST_PAD;
          else if (ld_ok) begin
            acc <= '0; lane <= '0; pay_cnt <= pay_cnt + 1'b1;
            st  <= ST_PAD;
          end
        end
        ST_PAD: if (!pay_cnt[0] || ld_ok) st <= ST_TRL;
        ST_TRL: if (ld_ok) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n || resync)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_no_take_stall_r9: assert property (@(posedge clk) disable iff (!rst_n || resync)
    out_valid && !out_ready |-> in_ready == '0);

  p_one_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~en_mask) == '0);

  p_even_length_r5: assert property (@(posedge clk) disable iff (!rst_n || resync)
    out_valid && out_last |-> !out_data[32] && out_data[63:60] == END_MARK);

  p_resync_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !out_valid && start_ready);
endmodule

// File: tb/evb_framer_tb.sv
`timescale 1ns/1ps
module evb_framer_tb;
  localparam int NB = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, resync;
  logic [NB-1:0]     en_mask;
  logic              start_valid, start_ready;
  logic [3:0]        start_type, start_fov;
  logic [23:0]       start_l1;
  logic [11:0]       start_bx, start_src;
  logic [NB-1:0]     in_valid, in_ready, in_last, in_absent;
  logic [NB*16-1:0]  in_data;
  logic [NB*7-1:0]   in_err;
  logic [NB*24-1:0]  in_evn;
  logic              out_valid, out_ready, out_last;
  logic [63:0]       out_data;

  evb_framer #(.N_IN(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .resync(resync), .en_mask(en_mask),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_type(start_type), .start_l1(start_l1), .start_bx(start_bx),
    .start_src(start_src), .start_fov(start_fov),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_absent(in_absent), .in_err(in_err), .in_evn(in_evn),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [17:0] iq [NB][$];     // {absent, last, word}
  logic [64:0] exp_q [$];      // {last, word}
  string       tag_q [$];
  bit          start_pend = 0, run_chk = 0, do_resync = 0;
  int          rdy_pct = 100;
  logic [NB-1:0] fire_p = '0;
  bit          start_fire_p = 0, out_fire_p = 0, prev_stall = 0;
  logic [64:0] prev_out = '0;

  logic [NB-1:0] ev_en;
  int            ev_dlen [NB];
  bit            ev_abs  [NB];
  logic [23:0]   ev_evn  [NB];
  logic [6:0]    ev_err  [NB];
  int            ev_seed = 0;

  task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [63:0] w);
    logic [15:0] r = c;
    for (int b = 63; b >= 0; b--) begin
      if (r[15] ^ w[b]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic push_exp(input logic [64:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // build stimulus queues and the expected word sequence (R1, R2, R5, R6, R7, R8)
  task automatic build_event();
    logic [15:0] w16 [$];
    logic [63:0] w, hdr, trl;
    logic [15:0] crc;
    logic [6:0]  eo;
    bit          ms;
    int          np, len;
    eo = '0; ms = 0;
    for (int i = 0; i < NB; i++) begin
      if (ev_en[i]) begin
        eo |= ev_err[i];
        if (ev_abs[i] || ev_evn[i] != start_l1) ms = 1;
        if (ev_abs[i]) iq[i].push_back({2'b11, 16'h0});
        else begin
          for (int k = 0; k < ev_dlen[i] + 4; k++) begin
            logic [15:0] d = 16'(i*4096 + k*17 + ev_seed*7 + 1);
            iq[i].push_back({1'b0, k == ev_dlen[i] + 3, d});
            w16.push_back(d);
          end
        end
      end else begin
        iq[i].push_back({2'b01, 16'hDEAD});
      end
    end
    hdr = {4'h5, start_type, start_l1, start_bx, start_src, start_fov, 4'h0};
    crc = ref_crc(16'hFFFF, hdr);
    push_exp({1'b0, hdr}, "R1 header");
    np = (w16.size() + 3) / 4;
    for (int p = 0; p < np; p++) begin
      w = '0;
      for (int j = 0; j < 4; j++)
        if (4*p + j < w16.size()) w[63 - 16*j -: 16] = w16[4*p + j];
      crc = ref_crc(crc, w);
      push_exp({1'b0, w}, "R2 payload");
    end
    if (np % 2 == 1) begin
      crc = ref_crc(crc, 64'h0);
      push_exp({1'b0, 64'h0}, "R5 pad");
    end
    len = np + 2 + (np % 2);
    trl = {4'hA, 4'h0, 24'(len), 16'h0, ms, eo, 8'h0};
    crc = ref_crc(crc, trl);
    trl[31:16] = crc;
    push_exp({1'b1, trl}, "R6 R7 R8 trailer");
  endtask

  // driver and per-clock comparison
  always @(negedge clk) begin
    bit skip = 0;
    for (int i = 0; i < NB; i++) if (fire_p[i] && iq[i].size() > 0) void'(iq[i].pop_front());
    if (start_fire_p) start_pend = 0;
    if (out_fire_p && exp_q.size() > 0) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
    if (do_resync) begin
      for (int i = 0; i < NB; i++) iq[i].delete();
      exp_q.delete(); tag_q.delete();
      start_pend = 0; do_resync = 0; resync = 1; skip = 1;
    end else resync = 0;
    for (int i = 0; i < NB; i++) begin
      in_valid[i]  = iq[i].size() > 0;
      in_data[i*16 +: 16] = in_valid[i] ? iq[i][0][15:0] : 16'h0;
      in_last[i]   = in_valid[i] ? iq[i][0][16] : 1'b0;
      in_absent[i] = in_valid[i] ? iq[i][0][17] : 1'b0;
      in_err[i*7 +: 7]   = ev_err[i];
      in_evn[i*24 +: 24] = ev_evn[i];
    end
    start_valid = start_pend;
    out_ready = ($urandom_range(99) < rdy_pct);
    #0.5;
    fire_p       = in_valid & in_ready;
    start_fire_p = start_valid && start_ready;
    out_fire_p   = out_valid && out_ready;
    if (run_chk && !skip) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected word", {out_last, out_data}, '0);
        else check({out_last, out_data} == exp_q[0], tag_q[0], {out_last, out_data}, exp_q[0]);
      end
      if (prev_stall)
        check(out_valid && {out_last, out_data} == prev_out, "R9 hold", {out_last, out_data}, prev_out);
      if (out_valid && !out_ready)
        check(in_ready == '0, "R9 no consume", 65'(in_ready), '0);
      check($countones(in_ready) <= 1, "R12 single ready", 65'(in_ready), '0);
      check((in_ready & ~ev_en) == '0, "R3 disabled ready", 65'(in_ready), '0);
    end
    prev_stall = out_valid && !out_ready && !skip;
    prev_out   = {out_last, out_data};
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic set_hdr(input int s);
    ev_seed    = s;
    start_type = 4'(s + 3);
    start_l1   = 24'h00A100 + 24'(s);
    start_bx   = 12'(12'h3F0 + s);
    start_src  = 12'h2B7;
    start_fov  = 4'h2;
    for (int i = 0; i < NB; i++) begin
      ev_evn[i] = start_l1; ev_err[i] = '0; ev_abs[i] = 0; ev_dlen[i] = 0;
    end
  endtask

  task automatic run_event(input int pct);
    int t = 0;
    @(posedge clk);
    en_mask = ev_en;
    rdy_pct = pct;
    build_event();
    start_pend = 1;
    while ((exp_q.size() != 0 || start_pend) && t < 20000) begin @(posedge clk); t++; end
    check(t < 20000, "R1 event completes", 65'(exp_q.size()), '0);
    repeat (3) @(posedge clk);
    for (int i = 0; i < NB; i++)
      if (!ev_en[i]) begin
        check(iq[i].size() == 1, "R3 disabled beat kept", 65'(iq[i].size()), 65'd1);
        iq[i].delete();
      end
  endtask

  initial begin
    rst_n = 0; resync = 0; en_mask = '0; ev_en = '0;
    start_valid = 0; out_ready = 0;
    in_valid = '0; in_data = '0; in_last = '0; in_absent = '0; in_err = '0; in_evn = '0;
    set_hdr(0);
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R11 reset valid", 65'(out_valid), '0);
    check(in_ready == '0, "R11 reset ready", 65'(in_ready), '0);
    check(start_ready, "R1 idle start_ready", 65'(start_ready), 65'd1);
    rst_n = 1;
    run_chk = 1;

    // all inputs, odd payload count -> pad (R2, R5)
    set_hdr(1); ev_en = 4'b1111;
    ev_dlen[0] = 2; ev_dlen[1] = 3; ev_dlen[2] = 1; ev_dlen[3] = 5;
    run_event(100);

    // same shape under back-pressure (R9)
    set_hdr(2); ev_en = 4'b1111;
    ev_dlen[0] = 2; ev_dlen[1] = 3; ev_dlen[2] = 1; ev_dlen[3] = 5;
    run_event(40);

    // two disabled inputs, even payload count -> no pad (R3, R5)
    set_hdr(3); ev_en = 4'b1010;
    ev_dlen[1] = 4; ev_dlen[3] = 4;
    run_event(70);

    // absent block, wrong event number, error flags (R4, R8)
    set_hdr(4); ev_en = 4'b1111;
    ev_dlen[0] = 3; ev_dlen[1] = 2; ev_dlen[3] = 6;
    ev_abs[2] = 1; ev_evn[0] = 24'h123456;
    ev_err[1] = 7'h05; ev_err[3] = 7'h40; ev_err[2] = 7'h02;
    run_event(60);

    // only an error flag set, no mismatch (R8)
    set_hdr(5); ev_en = 4'b0110;
    ev_dlen[1] = 1; ev_dlen[2] = 2; ev_err[2] = 7'h11;
    run_event(100);

    // no inputs enabled: header + trailer, length 2 (R5, R6)
    set_hdr(6); ev_en = 4'b0000;
    run_event(100);

    // resync in the middle of an event (R10)
    set_hdr(7); ev_en = 4'b1111;
    for (int i = 0; i < NB; i++) ev_dlen[i] = 20;
    @(posedge clk);
    en_mask = ev_en; rdy_pct = 50;
    build_event();
    start_pend = 1;
    repeat (15) @(posedge clk);
    do_resync = 1;
    @(negedge clk); @(negedge clk);
    #1;
    check(!out_valid, "R10 valid cleared", 65'(out_valid), '0);
    check(start_ready, "R10 back to idle", 65'(start_ready), 65'd1);
    check(in_ready == '0, "R10 no ready", 65'(in_ready), '0);

    // clean event after resync (R10, R2)
    set_hdr(8); ev_en = 4'b1101;
    ev_dlen[0] = 1; ev_dlen[2] = 2; ev_dlen[3] = 3;
    run_event(80);

    finish_run();
  end
endmodule